// File: doc/BRIEF.md
# Barrel Shifter With Carry

This block forms the second operand of a processor datapath. It takes a 32-bit value, a shift-type code, an 8-bit shift amount and the current carry flag. It returns the shifted value together with the carry-out that the flag logic would record. Five operations are supported: logical left, logical right, arithmetic right, rotate right, and a one-place rotate right that passes through the carry flag. Each of them treats an amount of zero, an amount of exactly the word width, and a larger amount as separate cases.

The shifting is combinational. It uses one logarithmic network of shift stages. A parameter adds an output register paired with a valid bit, so that every result comes out one clock after its input. A new result is loaded only when the input is marked valid. Between valid inputs the last result stays on the output.

Top module: `shifter_carry_unit`

## Requirements
- R1: Code 0 (logical left) with an amount n from 1 to 31 gives value<<n. The carry-out is input bit 32-n.
- R2: Code 1 (logical right) with an amount n from 1 to 31 gives value>>n with zero fill. The carry-out is input bit n-1.
- R3: Code 2 (arithmetic right) with an amount n from 1 to 31 fills the top n bits with input bit 31. The carry-out is input bit n-1.
- R4: An amount of exactly 32 gives these results. Code 0 gives zero with carry-out equal to input bit 0. Code 1 gives zero with carry-out equal to input bit 31. Code 2 gives 32 copies of input bit 31, and the carry-out is bit 31.
- R5: Codes 0 and 1 with an amount above 32 give zero, and the carry-out is 0.
- R6: Code 2 with an amount above 32 gives 32 copies of input bit 31, and the carry-out equals bit 31.
- R7: Code 3 (rotate right) with a non-zero amount rotates by the amount modulo 32. The carry-out equals bit 31 of the rotated result, so a non-zero multiple of 32 returns the input unchanged.
- R8: Code 4 rotates right one place through the carry. Bit 31 of the result is the incoming carry, bits 30..0 are input bits 31..1, and the carry-out is input bit 0. The amount has no effect.
- R9: An amount of zero with codes 0 to 3 passes the value unchanged, and the carry-out equals the incoming carry.
- R10: Codes 5, 6 and 7 pass the value unchanged for any amount, and the carry-out equals the incoming carry.
- R11: Reset clears out_valid, out_value and out_carry to 0. After reset, out_valid equals in_valid of the previous cycle, and the result of a valid input appears in the next cycle.
- R12: While in_valid is low, out_value and out_carry keep their last values, even if the other inputs change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output stage |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks the operand inputs as a request |
| in_value | input | 32 | Value to shift |
| in_kind | input | 3 | Shift-type code (0 left, 1 right, 2 arithmetic, 3 rotate, 4 rotate through carry) |
| in_amount | input | 8 | Shift amount |
| in_carry | input | 1 | Incoming carry flag |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_value | output | 32 | Shifted value |
| out_carry | output | 1 | Carry-out |

## Verification
The properties assume that the output register is present and one cycle deep. They also assume that in_value, in_kind, in_amount and in_carry are stable at the clock edge where in_valid is sampled high. The bench keeps to this: it changes inputs only on the falling edge and holds in_valid low throughout reset. Codes 5 to 7 and amounts up to 255 are legal inputs and are driven on purpose. Nothing else in the input space is excluded.

// File: rtl/shc_pkg.sv
package shc_pkg;

    typedef enum logic [2:0] {
        SHK_LSL = 3'd0,
        SHK_LSR = 3'd1,
        SHK_ASR = 3'd2,
        SHK_ROR = 3'd3,
        SHK_RRX = 3'd4
    } shift_kind_e;

    typedef struct packed {
        logic zero;   // amount is zero
        logic full;   // amount equals the word width
        logic over;   // amount exceeds the word width
    } amt_class_t;

    function automatic logic is_reserved(input logic [2:0] code);
        return code > 3'd4;
    endfunction

endpackage

// File: rtl/shc_amt_decode.sv
module shc_amt_decode
    import shc_pkg::*;
#(
    parameter int W     = 32,
    parameter int AMT_W = 8,
    localparam int SH_W = $clog2(W)
) (
    input  logic [AMT_W-1:0] amount,
    output amt_class_t       cls,
    output logic [SH_W-1:0]  shamt
);
    localparam logic [AMT_W-1:0] FULL = AMT_W'(W);

    always_comb begin
        cls.zero = (amount == '0);
        cls.full = (amount == FULL);
        cls.over = (amount > FULL);
        shamt    = amount[SH_W-1:0];
    end
endmodule

// File: rtl/shc_bitrev.sv
module shc_bitrev #(
    parameter int W = 32
) (
    input  logic [W-1:0] d_i,
    output logic [W-1:0] d_o
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        assign d_o[b] = d_i[W-1-b];
    end
endmodule

// File: rtl/shc_rshift.sv
module shc_rshift #(
    parameter int W = 32,
    localparam int SH_W = $clog2(W)
) (
    input  logic [W-1:0]    data_i,
    input  logic [SH_W-1:0] shamt,
    input  logic            fill,
    input  logic            rotate,
    output logic [W-1:0]    data_o
);
    logic [W-1:0] stage [0:SH_W];

    assign stage[0] = data_i;

    for (genvar i = 0; i < SH_W; i++) begin : g_stage
        localparam int D = 1 << i;
        logic [W-1:0] moved;
        assign moved = rotate ? {stage[i][D-1:0], stage[i][W-1:D]}
                              : {{D{fill}}, stage[i][W-1:D]};
        assign stage[i+1] = shamt[i] ? moved : stage[i];
    end

    assign data_o = stage[SH_W];
endmodule

// File: rtl/shifter_carry_unit.sv
module shifter_carry_unit
    import shc_pkg::*;
#(
    parameter int W         = 32,
    parameter int AMT_W     = 8,
    parameter bit OUT_STAGE = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [W-1:0]     in_value,
    input  logic [2:0]       in_kind,
    input  logic [AMT_W-1:0] in_amount,
    input  logic             in_carry,
    output logic             out_valid,
    output logic [W-1:0]     out_value,
    output logic             out_carry
);
    localparam int SH_W = $clog2(W);

    amt_class_t      cls;
    logic [SH_W-1:0] shamt;
    logic [W-1:0]    rev_in, sh_in, sh_out, rev_out;
    logic            is_left, fill, rotate, edge_bit, sign;
    logic [W-1:0]    res_value;
    logic            res_carry;

    shc_amt_decode #(.W(W), .AMT_W(AMT_W)) u_dec (
        .amount (in_amount),
        .cls    (cls),
        .shamt  (shamt)
    );

    shc_bitrev #(.W(W)) u_rev_in (.d_i(in_value), .d_o(rev_in));

    assign sign    = in_value[W-1];
    assign is_left = (in_kind == SHK_LSL);
    assign sh_in   = is_left ? rev_in : in_value;
    assign fill    = (in_kind == SHK_ASR) & sign;
    assign rotate  = (in_kind == SHK_ROR);

    shc_rshift #(.W(W)) u_shift (
        .data_i (sh_in),
        .shamt  (shamt),
        .fill   (fill),
        .rotate (rotate),
        .data_o (sh_out)
    );

    shc_bitrev #(.W(W)) u_rev_out (.d_i(sh_out), .d_o(rev_out));

    // last bit to leave the word, taken in the shift's own bit order
    assign edge_bit = sh_in[shamt - SH_W'(1)];

    always_comb begin
        res_value = in_value;
        res_carry = in_carry;
        if (is_reserved(in_kind)) begin
            res_value = in_value;
            res_carry = in_carry;
        end else if (in_kind == SHK_RRX) begin
            res_value = {in_carry, in_value[W-1:1]};
            res_carry = in_value[0];
        end else if (cls.zero) begin
            res_value = in_value;
            res_carry = in_carry;
        end else begin
            unique case (in_kind)
                SHK_LSL: begin
                    if (cls.over) begin
                        res_value = '0;
                        res_carry = 1'b0;
                    end else if (cls.full) begin
                        res_value = '0;
                        res_carry = in_value[0];
                    end else begin
                        res_value = rev_out;
                        res_carry = edge_bit;
                    end
                end
                SHK_LSR: begin
                    if (cls.over) begin
                        res_value = '0;
                        res_carry = 1'b0;
                    end else if (cls.full) begin
                        res_value = '0;
                        res_carry = sign;
                    end else begin
                        res_value = sh_out;
                        res_carry = edge_bit;
                    end
                end
                SHK_ASR: begin
                    if (cls.over || cls.full) begin
                        res_value = {W{sign}};
                        res_carry = sign;
                    end else begin
                        res_value = sh_out;
                        res_carry = edge_bit;
                    end
                end
                default: begin
                    res_value = sh_out;
                    res_carry = sh_out[W-1];
                end
            endcase
        end
    end

    if (OUT_STAGE) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                out_valid <= 1'b0;
                out_value <= '0;
                out_carry <= 1'b0;
            end else begin
                out_valid <= in_valid;
                if (in_valid) begin
                    out_value <= res_value;
                    out_carry <= res_carry;
                end
            end
        end
    end else begin : g_comb
        assign out_valid = in_valid;
        assign out_value = res_value;
        assign out_carry = res_carry;
    end
endmodule

// File: rtl/shc_checker.sv
module shc_checker #(
    parameter int W         = 32,
    parameter int AMT_W     = 8,
    parameter bit OUT_STAGE = 1'b1
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [W-1:0]     in_value,
    input logic [2:0]       in_kind,
    input logic [AMT_W-1:0] in_amount,
    input logic             in_carry,
    input logic             out_valid,
    input logic [W-1:0]     out_value,
    input logic             out_carry
);
    localparam logic [AMT_W-1:0] FULL = AMT_W'(W);

    if (OUT_STAGE) begin : g_props
        assert_valid_follows_R11: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) |-> (out_valid == $past(in_valid)));

        assert_hold_idle_R12: assert property (@(posedge clk) disable iff (rst)
            (!in_valid && !$past(rst)) |=> ($stable(out_value) && $stable(out_carry)));

        assert_zero_pass_R9: assert property (@(posedge clk) disable iff (rst)
            (in_valid && in_amount == '0 && in_kind < 3'd4)
            |=> (out_value == $past(in_value) && out_carry == $past(in_carry)));

        assert_reserved_pass_R10: assert property (@(posedge clk) disable iff (rst)
            (in_valid && in_kind > 3'd4)
            |=> (out_value == $past(in_value) && out_carry == $past(in_carry)));

        assert_logical_over_R5: assert property (@(posedge clk) disable iff (rst)
            (in_valid && in_kind < 3'd2 && in_amount > FULL)
            |=> (out_value == '0 && !out_carry));

        assert_arith_over_R6: assert property (@(posedge clk) disable iff (rst)
            (in_valid && in_kind == 3'd2 && in_amount > FULL)
            |=> (out_value == {W{$past(in_value[W-1])}} && out_carry == $past(in_value[W-1])));

        assert_rotate_carry_R7: assert property (@(posedge clk) disable iff (rst)
            (in_valid && in_kind == 3'd3 && in_amount != '0)
            |=> (out_carry == out_value[W-1]));

        assert_rrx_R8: assert property (@(posedge clk) disable iff (rst)
            (in_valid && in_kind == 3'd4)
            |=> (out_value == {$past(in_carry), $past(in_value[W-1:1])}
                 && out_carry == $past(in_value[0])));
    end
endmodule

bind shifter_carry_unit shc_checker #(.W(W), .AMT_W(AMT_W), .OUT_STAGE(OUT_STAGE)) u_chk (.*);

// File: tb/shifter_carry_unit_tb.sv
module shifter_carry_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_value = '0;
    logic [2:0]  in_kind = '0;
    logic [7:0]  in_amount = '0;
    logic        in_carry = 1'b0;
    logic        out_valid;
    logic [31:0] out_value;
    logic        out_carry;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    shifter_carry_unit u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_value(in_value),
        .in_kind(in_kind), .in_amount(in_amount), .in_carry(in_carry),
        .out_valid(out_valid), .out_value(out_value), .out_carry(out_carry)
    );

    // expected {carry, value}, written straight from the requirements
    function automatic logic [32:0] model(input logic [31:0] v, input logic [2:0] k,
                                          input logic [7:0] a, input logic c);
        logic [63:0] w;
        logic [31:0] r;
        int n;
        if (k > 3'd4) return {c, v};
        if (k == 3'd4) return {v[0], c, v[31:1]};
        if (a == 8'd0) return {c, v};
        case (k)
            3'd0: begin
                if (a > 8'd32) return 33'd0;
                w = {32'd0, v} << a;
                return {w[32], w[31:0]};
            end
            3'd1: begin
                if (a > 8'd32) return 33'd0;
                w = {v, 32'd0} >> a;
                return {w[31], w[63:32]};
            end
            3'd2: begin
                if (a > 8'd32) return {v[31], {32{v[31]}}};
                w = $signed({v, 32'd0}) >>> a;
                return {w[31], w[63:32]};
            end
            default: begin
                n = int'(a) % 32;
                w = {v, v} >> n;
                r = w[31:0];
                return {r[31], r};
            end
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [32:0] act, input logic [32:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // drive one request on a falling edge, check its result one cycle later
    task automatic run_op(input string req, input logic [31:0] v, input logic [2:0] k,
                          input logic [7:0] a, input logic c);
        logic [32:0] exp;
        exp = model(v, k, a, c);
        @(negedge clk);
        in_value = v; in_kind = k; in_amount = a; in_carry = c; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(req, "valid", {32'd0, out_valid}, 33'd1);
        check(req, "result", {out_carry, out_value}, exp);
    endtask

    task automatic test_reset();
        check("R11", "reset state", {out_valid, out_carry, out_value}, 33'd0);
    endtask

    task automatic test_lsl();
        run_op("R1", 32'h8000_0001, 3'd0, 8'd1, 1'b0);
        run_op("R1", 32'h0000_0001, 3'd0, 8'd31, 1'b1);
        run_op("R1", 32'h0000_0002, 3'd0, 8'd31, 1'b0);
        for (int i = 0; i < 8; i++)
            run_op("R1", $urandom, 3'd0, 8'($urandom_range(1, 31)), 1'($urandom));
    endtask

    task automatic test_lsr();
        run_op("R2", 32'h0000_0001, 3'd1, 8'd1, 1'b0);
        run_op("R2", 32'hC000_0000, 3'd1, 8'd31, 1'b0);
        for (int i = 0; i < 8; i++)
            run_op("R2", $urandom, 3'd1, 8'($urandom_range(1, 31)), 1'($urandom));
    endtask

    task automatic test_asr();
        run_op("R3", 32'h8000_0003, 3'd2, 8'd1, 1'b0);
        run_op("R3", 32'h8000_0000, 3'd2, 8'd31, 1'b0);
        run_op("R3", 32'h7FFF_FFFF, 3'd2, 8'd31, 1'b0);
        for (int i = 0; i < 8; i++)
            run_op("R3", $urandom, 3'd2, 8'($urandom_range(1, 31)), 1'($urandom));
    endtask

    task automatic test_full_width();
        run_op("R4", 32'h0000_0001, 3'd0, 8'd32, 1'b0);
        run_op("R4", 32'hFFFF_FFFE, 3'd0, 8'd32, 1'b1);
        run_op("R4", 32'h8000_0000, 3'd1, 8'd32, 1'b0);
        run_op("R4", 32'h7FFF_FFFF, 3'd1, 8'd32, 1'b1);
        run_op("R4", 32'h8000_1234, 3'd2, 8'd32, 1'b0);
        run_op("R4", 32'h7000_1234, 3'd2, 8'd32, 1'b1);
    endtask

    task automatic test_over();
        run_op("R5", 32'hFFFF_FFFF, 3'd0, 8'd33, 1'b1);
        run_op("R5", 32'hFFFF_FFFF, 3'd1, 8'd255, 1'b1);
        run_op("R5", $urandom, 3'd0, 8'd255, 1'b1);
        run_op("R6", 32'h8000_0000, 3'd2, 8'd33, 1'b0);
        run_op("R6", 32'h7FFF_FFFF, 3'd2, 8'd255, 1'b1);
    endtask

    task automatic test_ror();
        run_op("R7", 32'h0000_0001, 3'd3, 8'd1, 1'b0);
        run_op("R7", 32'h8000_0000, 3'd3, 8'd31, 1'b1);
        run_op("R7", 32'h1234_5678, 3'd3, 8'd32, 1'b0);
        run_op("R7", 32'h8765_4321, 3'd3, 8'd33, 1'b0);
        run_op("R7", 32'h0F0F_0F0E, 3'd3, 8'd255, 1'b1);
        for (int i = 0; i < 6; i++)
            run_op("R7", $urandom, 3'd3, 8'($urandom_range(1, 255)), 1'($urandom));
    endtask

    task automatic test_rrx();
        run_op("R8", 32'h0000_0001, 3'd4, 8'd0, 1'b1);
        run_op("R8", 32'hFFFF_FFFE, 3'd4, 8'd200, 1'b0);
        run_op("R8", $urandom, 3'd4, 8'd32, 1'b1);
    endtask

    task automatic test_zero();
        for (int k = 0; k < 4; k++) begin
            run_op("R9", 32'hA5A5_5A5A, 3'(k), 8'd0, 1'b1);
            run_op("R9", 32'h5A5A_A5A5, 3'(k), 8'd0, 1'b0);
        end
    endtask

    task automatic test_reserved();
        for (int k = 5; k < 8; k++) begin
            run_op("R10", $urandom, 3'(k), 8'd1, 1'b1);
            run_op("R10", 32'hFFFF_0000, 3'(k), 8'd255, 1'b0);
        end
    endtask

    task automatic test_hold();
        logic [32:0] kept;
        run_op("R12", 32'h0000_00F0, 3'd1, 8'd4, 1'b0);
        kept = model(32'h0000_00F0, 3'd1, 8'd4, 1'b0);
        in_value = 32'hFFFF_FFFF; in_kind = 3'd0; in_amount = 8'd33; in_carry = 1'b1;
        @(negedge clk);
        check("R11", "idle valid", {32'd0, out_valid}, 33'd0);
        check("R12", "held result", {out_carry, out_value}, kept);
        @(negedge clk);
        check("R12", "held result later", {out_carry, out_value}, kept);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        test_reset();
        test_lsl();
        test_lsr();
        test_asr();
        test_full_width();
        test_over();
        test_ror();
        test_rrx();
        test_zero();
        test_reserved();
        test_hold();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule